// File: doc/BRIEF.md
# Burst-Inhibited Byte-Port Bus Sizer

This block sits between an internal requester that issues 32-bit reads and writes and an external device with an 8-bit data port. Bursting is not used. Each accepted request becomes four separate byte cycles on the external pins, one after another. Each byte cycle runs through its own fixed phase sequence, which includes one address-setup clock before the device is selected.

During those cycles the block drives the address, the direction, the start and address-latch strobes, the chip select, the output enable, the byte/write enable, the size code and the burst indication. Read bytes are packed into one 32-bit word in big-endian lane order. Write bytes are sent out in that same order.

Each byte cycle is completed by an acknowledge. That acknowledge is either generated internally (auto-acknowledge, no wait states) or taken from an external acknowledge input. The requester sees a one-cycle done pulse after the fourth byte cycle has finished.

Top module: `ebus_byte_sizer`

## Requirements
- R1: Every accepted request, read or write, produces exactly four byte cycles. Each cycle starts with one clock in which `ext_start` and `ext_ale` are both high.
- R2: `ext_size` is 2'b00 while the first byte cycle is started and 2'b01 while each of the other three is started.
- R3: Each byte cycle runs start (one clock), address setup (one clock, no strobe high), select (`ext_sel` high for at least two clocks), then one end clock. With auto-acknowledge a whole request takes 20 clocks: `rsp_done` is high in the 20th cycle after the edge that accepted the request.
- R4: The addresses of the four byte cycles are base, base+1, base+2 and base+3, in that order, with full-width carry.
- R5: When `cfg_auto_ack` is 0, a byte cycle stays selected until `ext_ack` is sampled high in its second or a later select clock. Each extra clock of waiting adds one clock to the request.
- R6: `ext_ben` is high in the select clocks of write cycles. When `cfg_be_read` is 1 it is also high in read cycles; when it is 0 it never goes high in read cycles.
- R7: Lanes are big-endian. The byte read at the base address lands in `rsp_rdata[31:24]` and the byte at base+3 lands in `rsp_rdata[7:0]`. Writes drive `req_wdata[31:24]` on `ext_dout` first and `req_wdata[7:0]` last.
- R8: `ext_burst` stays low at all times.
- R9: `ext_rd` is high for reads and low for writes, and it holds its value across all four cycles. `rsp_done` is a single-clock pulse.
- R10: `req_ready` is low from the accept edge until the request finishes. A request presented while `req_ready` is low is ignored.
- R11: After reset `req_ready` is high, and `rsp_done`, `ext_start`, `ext_ale`, `ext_sel`, `ext_oe` and `ext_ben` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_auto_ack | input | 1 | 1: internal acknowledge; 0: wait for ext_ack |
| cfg_be_read | input | 1 | 1: byte enable also asserted on reads |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Base byte address |
| req_wdata | input | DATA_W | Write word |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Assembled read word, valid with rsp_done |
| ext_addr | output | ADDR_W | External byte address |
| ext_dout | output | LANE_W | Write byte to device |
| ext_din | input | LANE_W | Read byte from device |
| ext_rd | output | 1 | Direction, 1 = read |
| ext_start | output | 1 | Transfer start strobe |
| ext_ale | output | 1 | Address latch enable |
| ext_sel | output | 1 | Chip select |
| ext_oe | output | 1 | Output enable (reads) |
| ext_ben | output | 1 | Byte/write enable |
| ext_ack | input | 1 | External transfer acknowledge |
| ext_burst | output | 1 | Burst indication, held low |
| ext_size | output | 2 | Transfer size code |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 32-bit word and an 8-bit lane, which gives four byte cycles per request. With these values the bench can reach base addresses whose low byte is near 0xFF, so the byte-address increment carries into the upper bits, and a base near the top of the address space, so the address wraps. The tests mix auto-acknowledge with external acknowledge at several delays, run both byte-enable settings on reads and writes, and present a second request while a sequence is in progress.

// File: rtl/ebus_pkg.sv
// Shared types for the byte-port bus sizer.
// Assumes one phase register drives all external strobe decoding.
package ebus_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_S0,
        PH_AS,
        PH_S1,
        PH_S2,
        PH_S3
    } phase_t;

    localparam logic [1:0] SIZE_LONG = 2'b00;
    localparam logic [1:0] SIZE_BYTE = 2'b01;
endpackage

// File: rtl/ebus_phase_seq.sv
// Phase sequencer: steps each byte cycle through S0, AS, S1, S2, S3 and
// counts the lanes of one request. Assumes start is only raised in idle.
module ebus_phase_seq
    import ebus_pkg::*;
#(
    parameter int NLANES = 4,
    localparam int LIDX_W = (NLANES > 1) ? $clog2(NLANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ack,
    output phase_t            phase,
    output logic [LIDX_W-1:0] lane,
    output logic              finish
);
    localparam logic [LIDX_W-1:0] LAST_LANE = LIDX_W'(NLANES - 1);

    // Phase and lane registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            lane  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_S0;
                    lane  <= '0;
                end
                PH_S0:   phase <= PH_AS;
                PH_AS:   phase <= PH_S1;
                PH_S1:   phase <= PH_S2;
                PH_S2:   if (ack) phase <= PH_S3;
                PH_S3: begin
                    if (lane == LAST_LANE) begin
                        phase <= PH_IDLE;
                    end else begin
                        phase <= PH_S0;
                        lane  <= lane + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Last end clock of the request.
    always_comb finish = (phase == PH_S3) && (lane == LAST_LANE);
endmodule

// File: rtl/ebus_ack_gate.sv
// Acknowledge gate: produces the cycle-completing acknowledge in S2,
// either at once (auto) or when the external acknowledge is high.
module ebus_ack_gate
    import ebus_pkg::*;
(
    input  phase_t phase,
    input  logic   auto_ack,
    input  logic   ext_ack,
    output logic   ack
);
    // Acknowledge is only meaningful in the second select phase.
    always_comb ack = (phase == PH_S2) && (auto_ack || ext_ack);
endmodule

// File: rtl/ebus_lane_pack.sv
// Lane packer: picks the outgoing write byte for the current lane and
// gathers read bytes into a word, big-endian (lane 0 = top byte).
module ebus_lane_pack #(
    parameter int LANE_W = 8,
    parameter int NLANES = 4,
    localparam int DATA_W = LANE_W * NLANES,
    localparam int LIDX_W = (NLANES > 1) ? $clog2(NLANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [LIDX_W-1:0] lane,
    input  logic [LANE_W-1:0] din,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANE_W-1:0] dout,
    output logic [DATA_W-1:0] rdata
);
    logic [LANE_W-1:0] wr_slot [NLANES];

    // Slice the write word into lane slots, lane 0 taking the top byte.
    for (genvar g = 0; g < NLANES; g++) begin : g_slot
        assign wr_slot[g] = wdata[(NLANES-1-g)*LANE_W +: LANE_W];
    end

    // Select the slot of the active lane.
    always_comb begin
        dout = '0;
        for (int i = 0; i < NLANES; i++) begin
            if (lane == LIDX_W'(i)) dout = wr_slot[i];
        end
    end

    // Store an acknowledged read byte into its lane position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            for (int i = 0; i < NLANES; i++) begin
                if (lane == LIDX_W'(i)) rdata[(NLANES-1-i)*LANE_W +: LANE_W] <= din;
            end
        end
    end
endmodule

// File: rtl/ebus_byte_sizer.sv
// Burst-inhibited byte-port bus sizer: turns one word request into
// NLANES single-byte external cycles. Assumes the requester holds
// req_* stable until req_ready samples it, and that config inputs
// only change while idle.
module ebus_byte_sizer
    import ebus_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANE_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_auto_ack,
    input  logic              cfg_be_read,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [LANE_W-1:0] ext_dout,
    input  logic [LANE_W-1:0] ext_din,
    output logic              ext_rd,
    output logic              ext_start,
    output logic              ext_ale,
    output logic              ext_sel,
    output logic              ext_oe,
    output logic              ext_ben,
    input  logic              ext_ack,
    output logic              ext_burst,
    output logic [1:0]        ext_size
);
    localparam int NLANES = DATA_W / LANE_W;
    localparam int LIDX_W = (NLANES > 1) ? $clog2(NLANES) : 1;

    phase_t            phase;
    logic [LIDX_W-1:0] lane;
    logic              finish;
    logic              ack;
    logic              start;
    logic              in_select;
    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_q;

    ebus_phase_seq #(.NLANES(NLANES)) i_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .ack    (ack),
        .phase  (phase),
        .lane   (lane),
        .finish (finish)
    );

    ebus_ack_gate i_ack (
        .phase    (phase),
        .auto_ack (cfg_auto_ack),
        .ext_ack  (ext_ack),
        .ack      (ack)
    );

    ebus_lane_pack #(.LANE_W(LANE_W), .NLANES(NLANES)) i_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (ack && !write_q),
        .lane    (lane),
        .din     (ext_din),
        .wdata   (wdata_q),
        .dout    (ext_dout),
        .rdata   (rsp_rdata)
    );

    // Handshake: accept only while idle.
    always_comb begin
        req_ready = (phase == PH_IDLE);
        start     = req_valid && req_ready;
    end

    // Latch the request for the whole four-cycle sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
        end else if (start) begin
            base_q  <= req_addr;
            wdata_q <= req_wdata;
            write_q <= req_write;
        end
    end

    // Completion pulse one clock after the final end phase.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_done <= 1'b0;
        else        rsp_done <= finish;
    end

    // External strobe and address decoding from phase and lane.
    always_comb begin
        in_select = (phase == PH_S1) || (phase == PH_S2);
        ext_start = (phase == PH_S0);
        ext_ale   = (phase == PH_S0);
        ext_sel   = in_select;
        ext_oe    = in_select && !write_q;
        ext_ben   = in_select && (write_q || cfg_be_read);
        ext_rd    = !write_q;
        ext_burst = 1'b0;
        ext_size  = (lane == '0) ? SIZE_LONG : SIZE_BYTE;
        ext_addr  = base_q + ADDR_W'(lane);
    end
endmodule

// File: rtl/ebus_byte_sizer_chk.sv
// Checker for the bus sizer: watches the external pins and the request
// handshake. Assumes config inputs are steady during a request.
module ebus_byte_sizer_chk #(
    parameter int ADDR_W = 32,
    parameter int LANE_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_auto_ack,
    input logic              cfg_be_read,
    input logic              req_valid,
    input logic              req_ready,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [LANE_W-1:0] ext_dout,
    input logic              ext_rd,
    input logic              ext_start,
    input logic              ext_ale,
    input logic              ext_sel,
    input logic              ext_oe,
    input logic              ext_ben,
    input logic              ext_ack,
    input logic              ext_burst,
    input logic [1:0]        ext_size
);
    localparam int NLANES = DATA_W / LANE_W;
    localparam int CNT_W  = $clog2(NLANES) + 1;

    logic [CNT_W-1:0]  cyc_cnt;
    logic [ADDR_W-1:0] last_addr;
    logic [DATA_W-1:0] wd_q;

    // Count started byte cycles since the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_cnt   <= '0;
            last_addr <= '0;
            wd_q      <= '0;
        end else if (req_valid && req_ready) begin
            cyc_cnt <= '0;
            wd_q    <= req_wdata;
        end else if (ext_start) begin
            cyc_cnt   <= cyc_cnt + 1'b1;
            last_addr <= ext_addr;
        end
    end

    a_r1_four_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> cyc_cnt == CNT_W'(NLANES));
    a_r1_ale_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        ext_start |-> ext_ale);
    a_r2_size_code: assert property (@(posedge clk) disable iff (!rst_n)
        ext_start |-> ext_size == ((cyc_cnt == '0) ? 2'b00 : 2'b01));
    a_r3_setup_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ext_start |=> (!ext_sel && !ext_start && !ext_ale));
    a_r3_select_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ext_start |=> ##1 ext_sel);
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_start && cyc_cnt != '0) |-> ext_addr == last_addr + 1'b1);
    a_r5_hold_for_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_auto_ack && ext_sel && $past(ext_sel) && !ext_ack) |=> ext_sel);
    a_r6_read_enable_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_ben && ext_rd) |-> cfg_be_read);
    a_r7_first_write_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_start && !ext_rd && cyc_cnt == '0) |-> ext_dout == wd_q[DATA_W-1 -: LANE_W]);
    a_r8_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_burst);
    a_r9_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r9_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel && $past(ext_sel)) |-> $stable(ext_rd));
    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel || ext_start) |-> !req_ready);
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ext_sel && !ext_oe && !ext_ben && !ext_start));
endmodule

bind ebus_byte_sizer ebus_byte_sizer_chk #(
    .ADDR_W(ADDR_W), .LANE_W(LANE_W), .DATA_W(DATA_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_auto_ack (cfg_auto_ack),
    .cfg_be_read  (cfg_be_read),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_wdata    (req_wdata),
    .rsp_done     (rsp_done),
    .ext_addr     (ext_addr),
    .ext_dout     (ext_dout),
    .ext_rd       (ext_rd),
    .ext_start    (ext_start),
    .ext_ale      (ext_ale),
    .ext_sel      (ext_sel),
    .ext_oe       (ext_oe),
    .ext_ben      (ext_ben),
    .ext_ack      (ext_ack),
    .ext_burst    (ext_burst),
    .ext_size     (ext_size)
);

// File: tb/test_ebus_byte_sizer.sv
// Bench for the bus sizer: a vector table of requests walked by one
// loop, then directed tests for reset and a request while busy.
module test_ebus_byte_sizer;
    localparam int ADDR_W = 32;
    localparam int LANE_W = 8;
    localparam int DATA_W = 32;
    localparam int NVEC   = 6;

    // {write, ext-ack mode, be_read, ack threshold[3:0], addr[31:0], wdata[31:0]}
    localparam logic [70:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 4'd2, 32'h0000_1000, 32'h0},
        {1'b1, 1'b0, 1'b0, 4'd2, 32'h0000_20FD, 32'hDEAD_BEEF},
        {1'b0, 1'b0, 1'b1, 4'd2, 32'h1234_56FE, 32'h0},
        {1'b1, 1'b1, 1'b1, 4'd4, 32'h8000_0010, 32'hA1B2_C3D4},
        {1'b0, 1'b1, 1'b0, 4'd5, 32'hFFFF_FFFE, 32'h0},
        {1'b1, 1'b1, 1'b0, 4'd2, 32'h0000_0001, 32'h0102_0304}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_auto_ack = 1'b1;
    logic              cfg_be_read = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_done;
    logic [DATA_W-1:0] rsp_rdata;
    logic [ADDR_W-1:0] ext_addr;
    logic [LANE_W-1:0] ext_dout;
    logic [LANE_W-1:0] ext_din;
    logic              ext_rd, ext_start, ext_ale, ext_sel, ext_oe, ext_ben;
    logic              ext_ack = 1'b0;
    logic              ext_burst;
    logic [1:0]        ext_size;

    ebus_byte_sizer #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .DATA_W(DATA_W)) i_ebus_byte_sizer (
        .clk(clk), .rst_n(rst_n), .cfg_auto_ack(cfg_auto_ack), .cfg_be_read(cfg_be_read),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .ext_addr(ext_addr), .ext_dout(ext_dout),
        .ext_din(ext_din), .ext_rd(ext_rd), .ext_start(ext_start), .ext_ale(ext_ale),
        .ext_sel(ext_sel), .ext_oe(ext_oe), .ext_ben(ext_ben), .ext_ack(ext_ack),
        .ext_burst(ext_burst), .ext_size(ext_size)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    // Device model: each byte depends only on its address.
    function automatic logic [7:0] dev_byte(input logic [31:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction
    assign ext_din = dev_byte(ext_addr);

    // Monitor state, sampled at the falling edge.
    int          thr = 2;
    int          sel_cnt = 0;
    int          ts_n = 0;
    int          done_n = 0;
    logic [31:0] seen_addr [8];
    logic [1:0]  seen_size [8];
    logic [7:0]  seen_wb [8];
    logic        prev_ts = 0, prev2_ts = 0, prev_sel = 0;
    logic        gap_bad = 0, be_rd_seen = 0, oe_wr_seen = 0, burst_seen = 0, rw_bad = 0;
    logic        exp_rd = 1;

    always @(negedge clk) begin
        if (ext_start && ts_n < 8) begin
            seen_addr[ts_n] = ext_addr;
            seen_size[ts_n] = ext_size;
            ts_n = ts_n + 1;
        end
        if (ext_sel && !prev_sel && ts_n > 0) seen_wb[ts_n-1] = ext_dout;
        if (prev_ts && (ext_sel || ext_start)) gap_bad = 1;
        if (prev2_ts && !ext_sel) gap_bad = 1;
        if (ext_ben && ext_rd) be_rd_seen = 1;
        if (ext_oe && !ext_rd) oe_wr_seen = 1;
        if (ext_burst) burst_seen = 1;
        if (ext_sel && ext_rd != exp_rd) rw_bad = 1;
        if (rsp_done) done_n = done_n + 1;
        prev2_ts = prev_ts;
        prev_ts  = ext_start;
        prev_sel = ext_sel;
        sel_cnt  = ext_sel ? sel_cnt + 1 : 0;
        ext_ack  = (sel_cnt >= thr);
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            report();
        end
    end

    task automatic clear_mon();
        ts_n = 0; done_n = 0; gap_bad = 0; be_rd_seen = 0; oe_wr_seen = 0;
        burst_seen = 0; rw_bad = 0;
    endtask

    // Issue one request, optionally with an intruding request mid-way.
    task automatic run_req(input logic wr, input logic extm, input logic ber,
                           input int th, input logic [31:0] addr,
                           input logic [31:0] wd, input logic intrude);
        int n = 0;
        logic [31:0] exp_word;
        logic [31:0] got_word;
        int exp_lat;
        @(negedge clk);
        cfg_auto_ack = !extm; cfg_be_read = ber; thr = th; exp_rd = !wr;
        clear_mon();
        req_valid = 1; req_write = wr; req_addr = addr; req_wdata = wd;
        @(posedge clk); #1;
        chk(req_ready == 0, "R10", "ready after accept", {31'b0, req_ready}, 0);
        @(negedge clk);
        req_valid = 0; req_addr = 32'h5555_5555; req_wdata = 32'h0;
        while (1) begin
            @(posedge clk); #1;
            n++;
            if (intrude && n == 6) begin
                chk(req_ready == 0, "R10", "ready while busy", {31'b0, req_ready}, 0);
                @(negedge clk);
                req_valid = 1; req_write = !wr; req_addr = 32'h0BAD_0000;
                @(negedge clk);
                req_valid = 0;
                n++;
            end
            if (rsp_done || n > 400) break;
        end
        exp_lat = extm ? 20 + 4 * (th - 2) : 20;
        chk(n == exp_lat, extm ? "R5" : "R3", "done latency", n, exp_lat);
        exp_word = {dev_byte(addr), dev_byte(addr + 1), dev_byte(addr + 2), dev_byte(addr + 3)};
        if (!wr) chk(rsp_rdata == exp_word, "R7", "read word", rsp_rdata, exp_word);
        repeat (3) @(negedge clk);
        chk(ts_n == 4, "R1", "byte cycle count", ts_n, 4);
        for (int k = 0; k < 4; k++) begin
            chk(seen_addr[k] == addr + k, "R4", "cycle address", seen_addr[k], addr + k);
            chk(seen_size[k] == ((k == 0) ? 2'b00 : 2'b01), "R2", "size code",
                {30'b0, seen_size[k]}, (k == 0) ? 0 : 1);
        end
        if (wr) begin
            got_word = {seen_wb[0], seen_wb[1], seen_wb[2], seen_wb[3]};
            chk(got_word == wd, "R7", "write byte order", got_word, wd);
            chk(!oe_wr_seen, "R6", "oe on write", {31'b0, oe_wr_seen}, 0);
        end else begin
            chk(be_rd_seen == ber, "R6", "byte enable on read", {31'b0, be_rd_seen}, {31'b0, ber});
        end
        chk(!gap_bad, "R3", "setup gap", {31'b0, gap_bad}, 0);
        chk(!burst_seen, "R8", "burst indication", {31'b0, burst_seen}, 0);
        chk(!rw_bad, "R9", "direction", {31'b0, rw_bad}, 0);
        chk(done_n == 1, "R9", "done pulses", done_n, 1);
        chk(req_ready == 1, "R10", "ready after finish", {31'b0, req_ready}, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(req_ready == 1, "R11", "ready in reset", {31'b0, req_ready}, 1);
        chk({ext_start, ext_ale, ext_sel, ext_oe, ext_ben, rsp_done} == 6'b0, "R11",
            "strobes in reset", {26'b0, ext_start, ext_ale, ext_sel, ext_oe, ext_ben, rsp_done}, 0);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk); #1;
        chk(req_ready == 1 && !ext_sel, "R11", "idle after reset", {31'b0, req_ready}, 1);

        for (int v = 0; v < NVEC; v++) begin
            run_req(VEC[v][70], VEC[v][69], VEC[v][68], int'(VEC[v][67:64]),
                    VEC[v][63:32], VEC[v][31:0], 1'b0);
        end

        // Request presented mid-sequence must be ignored (R10).
        run_req(1'b0, 1'b0, 1'b0, 2, 32'h0000_4400, 32'h0, 1'b1);
        repeat (4) @(negedge clk);
        chk(ts_n == 4, "R10", "no extra cycles after intrusion", ts_n, 4);

        // Same with external acknowledge and a write.
        run_req(1'b1, 1'b1, 1'b1, 3, 32'h0000_00FF, 32'h1122_3344, 1'b1);
        repeat (4) @(negedge clk);
        chk(ts_n == 4, "R10", "no extra cycles after intrusion", ts_n, 4);

        report();
    end
endmodule